// File: doc/BRIEF.md
# Converter Sequencing Controller

This block drives an external 8-bit converter core with four input channels. Software writes a control byte that picks a channel, one of four sequencing modes and a clock prescaler. The write can also carry a run bit that starts a sequence. A timer trigger pulse can start a sequence on its own, using the configuration latched by the last write.

While a sequence runs, the block waits a prescaled number of clocks and then pulses a start strobe to the core, with the channel number alongside. It then waits for the core's done pulse and stores the returned sample in one of four result registers. After the last conversion of a sequence it raises a one-cycle finish interrupt. In the looping mode it then starts the next pass.

The core is reached through a plain handshake: a start strobe and channel number go out, and busy, done and an 8-bit sample come back.

Top module: `conv_sequencer`

## Requirements
- R1: Control byte layout is channel in bits [1:0], variant bit at bit 2, sweep bit at bit 3, prescale code in bits [6:4] and run at bit 7. When the sweep bit is 0, every conversion of the sequence uses the channel in bits [1:0].
- R2: With sweep=0 and variant=0, the selected channel is converted four times. Conversion k is stored in result register k (bits [8k+7:8k] of `res_bank`), and the sequence then ends.
- R3: With sweep=0 and variant=1, the selected channel is converted once into result register 0. Result registers 1 to 3 keep their previous values.
- R4: With sweep=1 and variant=0, channels 0, 1, 2 and 3 are converted once each, in that order. Conversion k goes to result register k, and the sequence then ends.
- R5: With sweep=1 and variant=1, the four-channel pass repeats, with a finish interrupt after each pass. A control write with run=0 returns the block to idle on the next clock. A conversion already in flight at that point is discarded.
- R6: The start strobe is a one-cycle pulse. It comes 2<<code clock edges after the edge that accepts a start, or after the edge that takes a done pulse that does not end the sequence. The prescale code is read from bits [6:4].
- R7: No start strobe is issued while `core_busy` is high. A strobe that is due is held, then issued on the first edge at which `core_busy` is low.
- R8: On the edge that takes the done pulse of the last conversion, `fin_irq` goes high for exactly one cycle. In the non-looping modes `seq_active` falls on that same edge.
- R9: A control write with run=0 while idle latches the configuration and starts nothing. A `tmr_trig` pulse while idle starts a sequence with the latched configuration.
- R10: While a sequence is active, a `tmr_trig` pulse or a write with run=1 is ignored. The configuration fields of such a write are not latched.
- R11: After reset the block is idle, the start strobe and interrupt are low, and all result registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| tmr_trig | input | 1 | Timer start pulse |
| conv_start | output | 1 | Start strobe to the converter core |
| conv_ch | output | 2 | Channel for the current conversion |
| core_busy | input | 1 | Core is converting |
| core_done | input | 1 | Core result valid pulse |
| core_data | input | 8 | Core result |
| seq_active | output | 1 | A sequence is in progress |
| fin_irq | output | 1 | Sequence finish pulse |
| res_bank | output | 32 | Four result registers, register k at bits [8k+7:8k] |

## Verification
The start strobe is due exactly 2<<code edges after the accepting edge. The bench counts rising edges from that edge and samples at the falling edge that follows each one, expecting the first high strobe at count 2 for code 0 and at count 256 for code 7. Interrupt, result registers and `seq_active` all change on the edge that takes the last done pulse, so they are compared together at the falling edge right after the interrupt is first seen. A stop write is checked one falling edge after its accepting edge. Its discarded conversion and a held strobe under a forced busy are each checked a fixed number of edges later.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    localparam int NUM_CH   = 4;
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int SMP_W    = 8;
    localparam int DIV_W    = 3;
    localparam int CNT_W    = 1 << DIV_W;
    localparam int RATIO_W  = CNT_W + 1;
    localparam int F_CH_LO  = 0;
    localparam int F_VAR    = CH_W;
    localparam int F_SWEEP  = CH_W + 1;
    localparam int F_DIV_LO = CH_W + 2;
    localparam int F_RUN    = CH_W + 2 + DIV_W;
    localparam int CTL_W    = F_RUN + 1;
    localparam int BANK_W   = NUM_CH * SMP_W;

    // encoding follows {sweep, variant}
    typedef enum logic [1:0] {
        MODE_SAME4      = 2'b00,
        MODE_SAME1      = 2'b01,
        MODE_SWEEP1     = 2'b10,
        MODE_SWEEP_LOOP = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_CONV = 2'b10
    } state_e;

    typedef struct packed {
        mode_e             mode;
        logic [DIV_W-1:0]  div;
        logic [CH_W-1:0]   ch;
    } cfg_t;

    function automatic cfg_t decode_ctl(input logic [CTL_W-1:0] w);
        cfg_t c;
        c.ch   = w[F_CH_LO +: CH_W];
        c.div  = w[F_DIV_LO +: DIV_W];
        c.mode = mode_e'({w[F_SWEEP], w[F_VAR]});
        return c;
    endfunction

    function automatic logic [RATIO_W-1:0] ratio_of(input logic [DIV_W-1:0] d);
        return RATIO_W'(2) << d;
    endfunction

    function automatic logic [CH_W-1:0] last_idx(input mode_e m);
        return (m == MODE_SAME1) ? '0 : CH_W'(NUM_CH - 1);
    endfunction

    function automatic logic sweeps(input mode_e m);
        return (m == MODE_SWEEP1) || (m == MODE_SWEEP_LOOP);
    endfunction
endpackage

// File: rtl/cs_ctl_reg.sv
module cs_ctl_reg
    import conv_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CTL_W-1:0]  wdata,
    input  logic              accept,
    output cfg_t              cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr && accept) begin
            cfg <= decode_ctl(wdata);
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(cfg)); // R10
endmodule

// File: rtl/cs_prescaler.sv
module cs_prescaler
    import conv_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [DIV_W-1:0]  div,
    output logic              tick
);
    logic [CNT_W-1:0] cnt;

    assign tick = ({1'b0, cnt} == (ratio_of(div) - RATIO_W'(1)));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        tick |-> $past(run)); // R6
endmodule

// File: rtl/cs_result_bank.sv
module cs_result_bank
    import conv_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [CH_W-1:0]    widx,
    input  logic [SMP_W-1:0]   wdata,
    output logic [BANK_W-1:0]  bank
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        logic [SMP_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (we && (widx == CH_W'(g))) begin
                slot_q <= wdata;
            end
        end
        assign bank[g*SMP_W +: SMP_W] = slot_q;
    end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
    import conv_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_wr,
    input  logic [CTL_W-1:0]   ctl_wdata,
    input  logic               tmr_trig,
    output logic               conv_start,
    output logic [CH_W-1:0]    conv_ch,
    input  logic               core_busy,
    input  logic               core_done,
    input  logic [SMP_W-1:0]   core_data,
    output logic               seq_active,
    output logic               fin_irq,
    output logic [BANK_W-1:0]  res_bank
);
    state_e          state;
    cfg_t            cfg;
    logic [CH_W-1:0] idx;
    logic            tick;
    logic            soc_q;
    logic            irq_q;
    logic            start_req;
    logic            stop_req;
    logic            res_we;
    logic            at_last;

    assign start_req  = (ctl_wr && ctl_wdata[F_RUN]) || tmr_trig;
    assign stop_req   = ctl_wr && !ctl_wdata[F_RUN];
    assign at_last    = (idx == last_idx(cfg.mode));
    assign res_we     = (state == ST_CONV) && core_done && !stop_req;
    assign seq_active = (state != ST_IDLE);
    assign conv_start = soc_q;
    assign fin_irq    = irq_q;
    assign conv_ch    = sweeps(cfg.mode) ? idx : cfg.ch;

    cs_ctl_reg u_ctl (
        .clk    (clk),
        .rst    (rst),
        .wr     (ctl_wr),
        .wdata  (ctl_wdata),
        .accept (state == ST_IDLE),
        .cfg    (cfg)
    );

    cs_prescaler u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_WAIT),
        .div  (cfg.div),
        .tick (tick)
    );

    cs_result_bank u_res (
        .clk   (clk),
        .rst   (rst),
        .we    (res_we),
        .widx  (idx),
        .wdata (core_data),
        .bank  (res_bank)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            soc_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            soc_q <= 1'b0;
            irq_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        state <= ST_WAIT;
                        idx   <= '0;
                    end
                end
                ST_WAIT: begin
                    if (stop_req) begin
                        state <= ST_IDLE;
                    end else if (tick && !core_busy) begin
                        soc_q <= 1'b1;
                        state <= ST_CONV;
                    end
                end
                ST_CONV: begin
                    if (stop_req) begin
                        state <= ST_IDLE;
                    end else if (core_done) begin
                        if (at_last) begin
                            irq_q <= 1'b1;
                            idx   <= '0;
                            state <= (cfg.mode == MODE_SWEEP_LOOP) ? ST_WAIT : ST_IDLE;
                        end else begin
                            idx   <= idx + CH_W'(1);
                            state <= ST_WAIT;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_SOC_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !$past(core_busy)); // R7
    AST_SOC_PULSE: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start); // R6
    AST_SOC_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> seq_active); // R6
    AST_FIN_PULSE: assert property (@(posedge clk) disable iff (rst)
        fin_irq |=> !fin_irq); // R8
    AST_FIN_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
        fin_irq |-> $past(core_done)); // R8
    AST_ONESHOT_ENDS: assert property (@(posedge clk) disable iff (rst)
        (fin_irq && cfg.mode != MODE_SWEEP_LOOP) |-> !seq_active); // R8
endmodule

// File: tb/conv_sequencer_test.sv
module conv_sequencer_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LAT = 3;
    localparam int NVEC = 6;
    // {ctl[7:0], conversions[3:0], 4'h0, channels {c3,c2,c1,c0}}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h82, 4'd4, 4'h0, 8'hAA},
        {8'h87, 4'd1, 4'h0, 8'h03},
        {8'h89, 4'd4, 4'h0, 8'hE4},
        {8'h90, 4'd4, 4'h0, 8'h00},
        {8'hB5, 4'd1, 4'h0, 8'h01},
        {8'hA8, 4'd4, 4'h0, 8'hE4}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00;
    logic        tmr_trig = 1'b0;
    logic        conv_start;
    logic [1:0]  conv_ch;
    logic        core_busy;
    logic        core_done;
    logic [7:0]  core_data;
    logic        seq_active;
    logic        fin_irq;
    logic [31:0] res_bank;

    logic        force_busy = 1'b0;
    logic        m_busy;
    int          m_timer;
    logic [1:0]  m_ch;
    logic [5:0]  m_serial;
    logic        m_done;
    logic [7:0]  m_data;
    logic [1:0]  log_ch [128];
    logic [7:0]  log_data [128];
    int          n_log;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign core_busy = m_busy | force_busy;
    assign core_done = m_done;
    assign core_data = m_data;

    conv_sequencer uut (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .tmr_trig   (tmr_trig),
        .conv_start (conv_start),
        .conv_ch    (conv_ch),
        .core_busy  (core_busy),
        .core_done  (core_done),
        .core_data  (core_data),
        .seq_active (seq_active),
        .fin_irq    (fin_irq),
        .res_bank   (res_bank)
    );

    // converter core model
    always @(posedge clk) begin
        m_done <= 1'b0;
        if (rst) begin
            m_busy   <= 1'b0;
            m_timer  <= 0;
            m_serial <= 6'd0;
            m_ch     <= 2'd0;
            m_data   <= 8'h00;
            n_log    <= 0;
        end else if (conv_start) begin
            m_busy  <= 1'b1;
            m_timer <= LAT;
            m_ch    <= conv_ch;
        end else if (m_busy) begin
            if (m_timer == 1) begin
                m_done   <= 1'b1;
                m_data   <= {m_ch, m_serial};
                m_busy   <= 1'b0;
                m_serial <= m_serial + 6'd1;
                log_ch[n_log[6:0]]   <= m_ch;
                log_data[n_log[6:0]] <= {m_ch, m_serial};
                n_log <= n_log + 1;
            end
            m_timer <= m_timer - 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(posedge clk); #1;
        ctl_wr = 1'b1; ctl_wdata = v;
        @(posedge clk); #1;
        ctl_wr = 1'b0;
    endtask

    task automatic pulse_trig();
        @(posedge clk); #1;
        tmr_trig = 1'b1;
        @(posedge clk); #1;
        tmr_trig = 1'b0;
    endtask

    task automatic wait_irq(output bit got);
        got = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (fin_irq) begin
                got = 1;
                break;
            end
        end
    endtask

    function automatic logic [7:0] slot(input logic [31:0] b, input int k);
        return b[k*8 +: 8];
    endfunction

    task automatic check_seq(input int base, input int n, input logic [7:0] chs,
                             input logic [31:0] prev, input string tag);
        check(n_log - base == n, {tag, " conversion count"}, n_log - base, n);
        for (int k = 0; k < 4; k++) begin
            if (k < n) begin
                check(log_ch[(base + k) % 128] == chs[2*k +: 2], {tag, " channel order"},
                      log_ch[(base + k) % 128], chs[2*k +: 2]);
                check(slot(res_bank, k) == log_data[(base + k) % 128], {tag, " result slot"},
                      slot(res_bank, k), log_data[(base + k) % 128]);
            end else begin
                check(slot(res_bank, k) == slot(prev, k), {tag, " untouched slot"},
                      slot(res_bank, k), slot(prev, k));
            end
        end
    endtask

    initial begin
        bit got;
        int base;
        int cnt;
        bit seen;
        logic [31:0] prev;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(res_bank == 32'h0, "R11 results zero", res_bank, 0);
        check(!seq_active && !conv_start && !fin_irq, "R11 idle outputs",
              {seq_active, conv_start, fin_irq}, 0);

        // table of modes: R1 R2 R3 R4
        for (int v = 0; v < NVEC; v++) begin
            prev = res_bank;
            base = n_log;
            wr_ctl(VEC[v][23:16]);
            wait_irq(got);
            check(got, "R8 finish interrupt seen", got, 1);
            check(!seq_active, "R8 active falls with interrupt", seq_active, 0);
            check_seq(base, int'(VEC[v][15:12]), VEC[v][7:0], prev, "R1 R2 R3 R4 mode table");
        end

        // R6 prescale timing, code 0 and code 7
        for (int t = 0; t < 2; t++) begin
            wr_ctl(t == 0 ? 8'h87 : 8'hF7);
            cnt = 0;
            seen = 0;
            while (cnt < 600) begin
                @(posedge clk);
                cnt++;
                @(negedge clk);
                if (conv_start) begin
                    seen = 1;
                    break;
                end
            end
            check(seen && cnt == (t == 0 ? 2 : 256), "R6 strobe delay", cnt, t == 0 ? 2 : 256);
            @(negedge clk);
            check(!conv_start, "R6 strobe one cycle", conv_start, 0);
            wait_irq(got);
        end

        // R9 config-only write then timer start
        prev = res_bank;
        base = n_log;
        wr_ctl(8'h08);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (conv_start || seq_active) seen = 1;
        end
        check(!seen, "R9 run=0 write starts nothing", seen, 0);
        pulse_trig();
        wait_irq(got);
        check(got, "R9 trigger completes", got, 1);
        check_seq(base, 4, 8'hE4, prev, "R9 trigger sweep");

        // R10 start requests during a sequence are ignored
        prev = res_bank;
        base = n_log;
        wr_ctl(8'h91);
        repeat (2) @(posedge clk);
        pulse_trig();
        wr_ctl(8'h8B);
        wait_irq(got);
        check_seq(base, 4, 8'h55, prev, "R10 ignored restart");
        repeat (5) @(negedge clk);
        check(!seq_active, "R10 no late restart", seq_active, 0);

        // R5 looping sweep and stop
        base = n_log;
        wr_ctl(8'h8C);
        wait_irq(got);
        @(negedge clk);
        check(seq_active, "R5 loop continues after pass", seq_active, 1);
        wait_irq(got);
        check(got && n_log - base == 8, "R5 two passes", n_log - base, 8);
        for (int k = 0; k < 4; k++)
            check(log_ch[(base + 4 + k) % 128] == 2'(k), "R5 second pass order",
                  log_ch[(base + 4 + k) % 128], k);
        seen = 0;
        for (int i = 0; i < 50 && !seen; i++) begin
            @(negedge clk);
            if (conv_start) seen = 1;
        end
        prev = res_bank;
        wr_ctl(8'h00);
        @(negedge clk);
        check(!seq_active, "R5 stop returns to idle", seq_active, 0);
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (conv_start || fin_irq) seen = 1;
        end
        check(!seen, "R5 no activity after stop", seen, 0);
        check(res_bank == prev, "R5 in-flight result discarded", res_bank, prev);

        // R7 strobe held while core busy
        force_busy = 1'b1;
        wr_ctl(8'h84);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (conv_start) seen = 1;
        end
        check(!seen, "R7 no strobe while busy", seen, 0);
        @(posedge clk); #1;
        force_busy = 1'b0;
        @(negedge clk);
        check(!conv_start, "R7 not before release edge", conv_start, 0);
        @(posedge clk);
        @(negedge clk);
        check(conv_start, "R7 strobe on first free edge", conv_start, 1);
        wait_irq(got);
        check(got, "R7 held sequence completes", got, 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #600000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule